// File: doc/BRIEF.md
# Lane Start-of-Transmission Sequencer

This block drives the low-power line states and the high-speed entry and exit phases of one clock lane and one data lane of a D-PHY style transmitter. It runs on the byte clock. Every timed phase lasts for a count taken from a timing register and measured in byte-clock cycles. At 432 Mbit/s one count is about 18.5 ns, so a zero-drive count of 10 gives about 185 ns and a count of 6 gives only about 111 ns. The analog drivers, the serializer and escape signalling sit outside the block. It only says which line state each lane must show, when high-speed drive is on, when the lane must drive HS-0, and when a payload byte may pass.

A burst begins with a start request. The clock lane comes up first and completes its own HS-0 period. Only then does the data lane step through its entry states. Payload bytes then pass on a valid/ready handshake, and an end request closes the burst through trail and exit phases. The clock lane can stay in continuous high-speed operation between bursts, as video streaming needs. Otherwise it shuts down after the data lane has gone idle.

Timing register layout: `tim_clk` and `tim_dat` each hold prepare in bits [CW-1:0], zero in [2CW-1:CW] and trail in [3CW-1:2CW]. `tim_exit` holds the data-lane exit count in [CW-1:0] and the clock-lane exit count in [2CW-1:CW]. Line-state codes put Dp in bit 1 and Dn in bit 0: 2'b11 is LP-11, 2'b01 is LP-01 and 2'b00 is LP-00. Both lanes show 2'b00 while they drive high speed.

Top module: `lane_sot_seq`

## Requirements
- R1: After reset both lanes show LP-11 (2'b11), with HS enable, zero drive, busy and `pay_ready` all low.
- R2: A data-lane burst shows LP-11, then LP-01 (2'b01) for LPX_CYC cycles (default 2), then LP-00 (2'b00, HS enable low) for the data prepare count, then HS-0 (HS enable and zero drive high) for the data zero count, and then the payload state (HS enable high, zero low, `pay_ready` high).
- R3: Every timed phase lasts exactly its field value in cycles, and a field value of 0 lasts one cycle.
- R4: The clock lane shows LP-01 for LPX_CYC cycles, LP-00 for the clock prepare count and HS-0 for the clock zero count, and then runs (HS enable high, zero low). The data lane shows LP-01 only while the clock lane is running.
- R5: `pay_ready` is high only in the payload state. A byte passes on each cycle with both `pay_valid` and `pay_ready` high, and `hs_byte` holds the last byte that passed, from the cycle after it passed.
- R6: `eob_req` is ignored while `pay_valid` is high. `eob_req` high with `pay_valid` low in the payload state starts the trail phase (HS enable high, zero low, `pay_ready` low) for the data trail count. The lane then shows LP-11 with busy high for the data exit count, and then busy falls.
- R7: With `clk_cont` low, the clock lane leaves the running state once the data lane is idle. It shows HS-0 trail for the clock trail count, then LP-11 with busy high for the clock exit count, and then goes idle.
- R8: With `clk_cont` high the clock lane starts from idle without a request and stays running between bursts. Once `clk_cont` is low and the data lane is idle, it performs the R7 shutdown.
- R9: The timing registers are captured when a request is accepted. A change during a burst does not alter that burst's phase lengths.
- R10: A request is accepted when the data lane is idle and the clock lane is idle or running. `dat_busy` rises in the cycle after acceptance and stays high until the exit phase ends. A request made while the data lane is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sot_req | input | 1 | Start-of-burst request |
| eob_req | input | 1 | End-of-burst request |
| pay_valid | input | 1 | Payload byte valid |
| pay_data | input | DW | Payload byte |
| pay_ready | output | 1 | Payload byte accepted this cycle when valid |
| clk_cont | input | 1 | Keep the clock lane in continuous high speed |
| tim_clk | input | 3*CW | Clock-lane trail, zero and prepare counts |
| tim_dat | input | 3*CW | Data-lane trail, zero and prepare counts |
| tim_exit | input | 2*CW | Clock-lane and data-lane exit counts |
| clk_lp | output | 2 | Clock-lane line state {Dp, Dn} |
| clk_hs_en | output | 1 | Clock-lane high-speed drive enable |
| clk_zero | output | 1 | Clock lane drives HS-0 |
| clk_busy | output | 1 | Clock lane out of idle |
| dat_lp | output | 2 | Data-lane line state {Dp, Dn} |
| dat_hs_en | output | 1 | Data-lane high-speed drive enable |
| dat_zero | output | 1 | Data lane drives HS-0 |
| dat_busy | output | 1 | Data lane busy, from acceptance to end of exit |
| hs_byte | output | DW | Last accepted payload byte, to the serializer |

## Verification
The properties assume only that reset is applied before the first burst. They place no limit on the timing fields, because any value, zero included, must still give a legal order of phases. The stimulus raises a request only while the lane can accept it or, on purpose, in the middle of a payload. It holds `pay_valid` high until the intended number of bytes has passed and raises `eob_req` either together with the payload or after it. It changes timing fields only after a request has been accepted, and it changes `clk_cont` only between bursts.

// File: rtl/lane_sot_pkg.sv
package lane_sot_pkg;

   typedef enum logic [1:0] {
      LP_BOTH_LOW = 2'b00,
      LP_REQ      = 2'b01,
      LP_ALT      = 2'b10,
      LP_STOP     = 2'b11
   } lp_code_t;

   typedef enum logic [2:0] {
      C_IDLE, C_RQST, C_PREP, C_ZERO, C_RUN, C_TRAIL, C_EXIT
   } clk_st_t;

   typedef enum logic [2:0] {
      D_IDLE, D_WAIT, D_RQST, D_PREP, D_ZERO, D_DATA, D_TRAIL, D_EXIT
   } dat_st_t;

endpackage

// File: rtl/lane_phase_timer.sv
module lane_phase_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] len,
   output logic          done
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt;

   generate
      if (CW < 2) begin : g_bad_width
         $error("lane_phase_timer: CW must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= (len == '0) ? '0 : len - ONE;
      else if (cnt != '0)
         cnt <= cnt - ONE;
   end

   assign done = (cnt == '0);

   // R3
   timer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (len > ONE)) |=> !done);

endmodule

// File: rtl/lane_clk_fsm.sv
module lane_clk_fsm
   import lane_sot_pkg::*;
#(
   parameter int CW      = 8,
   parameter int LPX_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          stop_ok,
   input  logic [CW-1:0] t_prep,
   input  logic [CW-1:0] t_zero,
   input  logic [CW-1:0] t_trail,
   input  logic [CW-1:0] t_exit,
   output logic [1:0]    lp,
   output logic          hs_en,
   output logic          zero,
   output logic          busy,
   output logic          idle,
   output logic          running
);
   localparam logic [CW-1:0] LPX_LEN = CW'(LPX_CYC);

   clk_st_t       st, st_n;
   logic          ld;
   logic [CW-1:0] ld_len;
   logic          done;

   lane_phase_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(ld), .len(ld_len), .done(done)
   );

   always_comb begin
      st_n   = st;
      ld     = 1'b0;
      ld_len = '0;
      case (st)
         C_IDLE:  if (start)   begin st_n = C_RQST;  ld = 1'b1; ld_len = LPX_LEN; end
         C_RQST:  if (done)    begin st_n = C_PREP;  ld = 1'b1; ld_len = t_prep;  end
         C_PREP:  if (done)    begin st_n = C_ZERO;  ld = 1'b1; ld_len = t_zero;  end
         C_ZERO:  if (done)    st_n = C_RUN;
         C_RUN:   if (stop_ok) begin st_n = C_TRAIL; ld = 1'b1; ld_len = t_trail; end
         C_TRAIL: if (done)    begin st_n = C_EXIT;  ld = 1'b1; ld_len = t_exit;  end
         C_EXIT:  if (done)    st_n = C_IDLE;
         default: st_n = C_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= C_IDLE;
      else        st <= st_n;
   end

   always_comb begin
      case (st)
         C_IDLE, C_EXIT: lp = LP_STOP;
         C_RQST:         lp = LP_REQ;
         default:        lp = LP_BOTH_LOW;
      endcase
   end

   assign hs_en   = (st == C_ZERO) || (st == C_RUN) || (st == C_TRAIL);
   assign zero    = (st == C_ZERO) || (st == C_TRAIL);
   assign busy    = (st != C_IDLE);
   assign idle    = (st == C_IDLE);
   assign running = (st == C_RUN);

   // R8
   clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == C_RUN && !stop_ok) |=> (st == C_RUN));

endmodule

// File: rtl/lane_dat_fsm.sv
module lane_dat_fsm
   import lane_sot_pkg::*;
#(
   parameter int CW      = 8,
   parameter int DW      = 8,
   parameter int LPX_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          clk_run,
   input  logic          pay_valid,
   input  logic [DW-1:0] pay_data,
   input  logic          eob_req,
   input  logic [CW-1:0] t_prep,
   input  logic [CW-1:0] t_zero,
   input  logic [CW-1:0] t_trail,
   input  logic [CW-1:0] t_exit,
   output logic [1:0]    lp,
   output logic          hs_en,
   output logic          zero,
   output logic          ready,
   output logic          busy,
   output logic          idle,
   output logic [DW-1:0] hs_byte
);
   localparam logic [CW-1:0] LPX_LEN = CW'(LPX_CYC);

   dat_st_t       st, st_n;
   logic          ld;
   logic [CW-1:0] ld_len;
   logic          done;

   lane_phase_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(ld), .len(ld_len), .done(done)
   );

   always_comb begin
      st_n   = st;
      ld     = 1'b0;
      ld_len = '0;
      case (st)
         D_IDLE:  if (accept)  st_n = D_WAIT;
         D_WAIT:  if (clk_run) begin st_n = D_RQST; ld = 1'b1; ld_len = LPX_LEN; end
         D_RQST:  if (done)    begin st_n = D_PREP; ld = 1'b1; ld_len = t_prep;  end
         D_PREP:  if (done)    begin st_n = D_ZERO; ld = 1'b1; ld_len = t_zero;  end
         D_ZERO:  if (done)    st_n = D_DATA;
         D_DATA:  if (!pay_valid && eob_req) begin
                     st_n = D_TRAIL; ld = 1'b1; ld_len = t_trail;
                  end
         D_TRAIL: if (done)    begin st_n = D_EXIT; ld = 1'b1; ld_len = t_exit; end
         D_EXIT:  if (done)    st_n = D_IDLE;
         default: st_n = D_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= D_IDLE;
      else        st <= st_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hs_byte <= '0;
      else if (st == D_DATA && pay_valid)
         hs_byte <= pay_data;
   end

   always_comb begin
      case (st)
         D_IDLE, D_WAIT, D_EXIT: lp = LP_STOP;
         D_RQST:                 lp = LP_REQ;
         default:                lp = LP_BOTH_LOW;
      endcase
   end

   assign hs_en = (st == D_ZERO) || (st == D_DATA) || (st == D_TRAIL);
   assign zero  = (st == D_ZERO);
   assign ready = (st == D_DATA);
   assign busy  = (st != D_IDLE);
   assign idle  = (st == D_IDLE);

   // R6
   eob_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == D_DATA && pay_valid) |=> (st == D_DATA));

endmodule

// File: rtl/lane_sot_seq.sv
module lane_sot_seq
   import lane_sot_pkg::*;
#(
   parameter int CW      = 8,
   parameter int DW      = 8,
   parameter int LPX_CYC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sot_req,
   input  logic            eob_req,
   input  logic            pay_valid,
   input  logic [DW-1:0]   pay_data,
   output logic            pay_ready,
   input  logic            clk_cont,
   input  logic [3*CW-1:0] tim_clk,
   input  logic [3*CW-1:0] tim_dat,
   input  logic [2*CW-1:0] tim_exit,
   output logic [1:0]      clk_lp,
   output logic            clk_hs_en,
   output logic            clk_zero,
   output logic            clk_busy,
   output logic [1:0]      dat_lp,
   output logic            dat_hs_en,
   output logic            dat_zero,
   output logic            dat_busy,
   output logic [DW-1:0]   hs_byte
);
   localparam int TW = 3 * CW;
   localparam int EW = 2 * CW;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("lane_sot_seq: DW must be at least 1");
      end
      if (LPX_CYC < 1 || LPX_CYC >= (1 << CW)) begin : g_bad_lpx
         $error("lane_sot_seq: LPX_CYC must fit in CW bits and be nonzero");
      end
   endgenerate

   logic          c_idle, c_run, d_idle;
   logic          accept, cap, stop_ok;
   logic [TW-1:0] clk_q, dat_q;
   logic [EW-1:0] ext_q;

   assign accept  = sot_req && d_idle && (c_idle || c_run);
   assign cap     = accept || (c_idle && clk_cont);
   assign stop_ok = d_idle && !accept && !clk_cont;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q <= '0;
         dat_q <= '0;
         ext_q <= '0;
      end else if (cap) begin
         clk_q <= tim_clk;
         dat_q <= tim_dat;
         ext_q <= tim_exit;
      end
   end

   lane_clk_fsm #(.CW(CW), .LPX_CYC(LPX_CYC)) u_clk (
      .clk(clk), .rst_n(rst_n),
      .start(accept || clk_cont), .stop_ok(stop_ok),
      .t_prep(clk_q[CW-1:0]), .t_zero(clk_q[2*CW-1:CW]),
      .t_trail(clk_q[3*CW-1:2*CW]), .t_exit(ext_q[2*CW-1:CW]),
      .lp(clk_lp), .hs_en(clk_hs_en), .zero(clk_zero), .busy(clk_busy),
      .idle(c_idle), .running(c_run)
   );

   lane_dat_fsm #(.CW(CW), .DW(DW), .LPX_CYC(LPX_CYC)) u_dat (
      .clk(clk), .rst_n(rst_n),
      .accept(accept), .clk_run(c_run),
      .pay_valid(pay_valid), .pay_data(pay_data), .eob_req(eob_req),
      .t_prep(dat_q[CW-1:0]), .t_zero(dat_q[2*CW-1:CW]),
      .t_trail(dat_q[3*CW-1:2*CW]), .t_exit(ext_q[CW-1:0]),
      .lp(dat_lp), .hs_en(dat_hs_en), .zero(dat_zero), .ready(pay_ready),
      .busy(dat_busy), .idle(d_idle), .hs_byte(hs_byte)
   );

   // R4
   data_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_lp == LP_REQ) |-> (clk_hs_en && !clk_zero));

   // R5
   ready_in_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pay_ready |-> (dat_hs_en && !dat_zero && dat_lp == LP_BOTH_LOW));

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_busy |=> ($stable(dat_q) && $stable(ext_q)));

   // R1
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dat_busy |-> (dat_lp == LP_STOP && !dat_hs_en && !pay_ready));

endmodule

// File: tb/lane_sot_seq_test.sv
module lane_sot_seq_test;
   localparam int CW  = 8;
   localparam int DW  = 8;
   localparam int LPX = 2;
   localparam logic [7:0] BASE = 8'h50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sot_req = 1'b0, eob_req = 1'b0, pay_valid = 1'b0, clk_cont = 1'b0;
   logic [DW-1:0] pay_data = '0;
   logic [3*CW-1:0] tim_clk = '0, tim_dat = '0;
   logic [2*CW-1:0] tim_exit = '0;
   logic pay_ready, clk_hs_en, clk_zero, clk_busy, dat_hs_en, dat_zero, dat_busy;
   logic [1:0] clk_lp, dat_lp;
   logic [DW-1:0] hs_byte;

   lane_sot_seq #(.CW(CW), .DW(DW), .LPX_CYC(LPX)) uut (
      .clk(clk), .rst_n(rst_n), .sot_req(sot_req), .eob_req(eob_req),
      .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
      .clk_cont(clk_cont), .tim_clk(tim_clk), .tim_dat(tim_dat), .tim_exit(tim_exit),
      .clk_lp(clk_lp), .clk_hs_en(clk_hs_en), .clk_zero(clk_zero), .clk_busy(clk_busy),
      .dat_lp(dat_lp), .dat_hs_en(dat_hs_en), .dat_zero(dat_zero), .dat_busy(dat_busy),
      .hs_byte(hs_byte)
   );

   always #10 clk = ~clk;

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic mon_clr = 1'b0;
   int d_lp01, d_lp00, d_zero, d_trail, d_exit, n_bytes, order_bad;
   int c_lp01, c_lp00, c_zero, c_trail, c_exit;
   bit d_seen_trail, c_seen_run;

   always @(negedge clk) begin
      if (mon_clr) begin
         d_lp01 = 0; d_lp00 = 0; d_zero = 0; d_trail = 0; d_exit = 0;
         n_bytes = 0; order_bad = 0; d_seen_trail = 0;
         c_lp01 = 0; c_lp00 = 0; c_zero = 0; c_trail = 0; c_exit = 0; c_seen_run = 0;
      end else begin
         if (dat_lp == 2'b01) d_lp01++;
         else if (!dat_hs_en && dat_lp == 2'b00) d_lp00++;
         else if (dat_hs_en && dat_zero) d_zero++;
         else if (dat_hs_en && pay_ready) ;
         else if (dat_hs_en) begin d_trail++; d_seen_trail = 1; end
         else if (dat_busy && d_seen_trail) d_exit++;
         if (pay_valid && pay_ready) n_bytes++;
         if (dat_lp == 2'b01 && !(clk_hs_en && !clk_zero)) order_bad++;
         if (clk_lp == 2'b01) c_lp01++;
         else if (!clk_hs_en && clk_lp == 2'b00) c_lp00++;
         else if (clk_hs_en && clk_zero) begin
            if (c_seen_run) c_trail++; else c_zero++;
         end
         else if (clk_hs_en) c_seen_run = 1;
         else if (clk_busy && c_seen_run) c_exit++;
      end
   end

   task automatic summary();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 150000);
            summary();
            $finish;
         end
      end
   end

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic check_eq(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      tick(); mon_clr = 1'b1;
      tick(); mon_clr = 1'b0;
   endtask

   function automatic logic [3*CW-1:0] pack3(int prep, int zero, int trail);
      return {CW'(trail), CW'(zero), CW'(prep)};
   endfunction

   task automatic run_burst(int nbytes, bit eob_early, bit extra_req,
                            bit change_cfg, bit wait_clk);
      int guard;
      clear_mon();
      sot_req = 1'b1;
      tick();
      check_eq("R10 busy after accept", int'(dat_busy), 1);
      sot_req = 1'b0;
      if (change_cfg) begin
         tim_dat  = pack3(7, 7, 7);
         tim_exit = {8'd7, 8'd7};
         tim_clk  = pack3(7, 7, 7);
      end
      pay_valid = 1'b1;
      pay_data  = BASE;
      if (eob_early) eob_req = 1'b1;
      guard = 0;
      while (n_bytes < nbytes && guard < 1000) begin
         tick();
         guard++;
         pay_data = BASE + 8'(n_bytes);
         sot_req  = (extra_req && n_bytes == 1);
      end
      pay_valid = 1'b0;
      eob_req   = 1'b1;
      sot_req   = 1'b0;
      while (dat_busy && guard < 2000) begin tick(); guard++; end
      eob_req = 1'b0;
      if (wait_clk)
         while (clk_busy && guard < 3000) begin tick(); guard++; end
      tick(); tick();
      if (guard >= 1000) check_eq("burst timeout", guard, 0);
   endtask

   task automatic check_data(string tag, int dp, int dz, int dt, int dx, int nb);
      check_eq({tag, " R2 lp01"}, d_lp01, LPX);
      check_eq({tag, " R2 prepare"}, d_lp00, dp);
      check_eq({tag, " R2 zero"}, d_zero, dz);
      check_eq({tag, " R5 bytes"}, n_bytes, nb);
      check_eq({tag, " R5 last byte"}, int'(hs_byte), int'(BASE) + nb - 1);
      check_eq({tag, " R6 trail"}, d_trail, dt);
      check_eq({tag, " R6 exit"}, d_exit, dx);
      check_eq({tag, " R4 order"}, order_bad, 0);
      check_eq({tag, " R10 idle after"}, int'(dat_busy), 0);
   endtask

   task automatic check_clock(string tag, int cp, int cz, int ct, int cx);
      check_eq({tag, " R4 clk lp01"}, c_lp01, LPX);
      check_eq({tag, " R4 clk prepare"}, c_lp00, cp);
      check_eq({tag, " R4 clk zero"}, c_zero, cz);
      check_eq({tag, " R7 clk trail"}, c_trail, ct);
      check_eq({tag, " R7 clk exit"}, c_exit, cx);
      check_eq({tag, " R7 clk idle"}, int'(clk_busy), 0);
   endtask

   task automatic test_reset();
      check_eq("R1 dat lp", int'(dat_lp), 3);
      check_eq("R1 clk lp", int'(clk_lp), 3);
      check_eq("R1 hs off", int'({clk_hs_en, dat_hs_en, clk_zero, dat_zero}), 0);
      check_eq("R1 busy/ready", int'({clk_busy, dat_busy, pay_ready}), 0);
   endtask

   task automatic set_std();
      tim_clk  = pack3(3, 5, 2);
      tim_dat  = pack3(2, 6, 3);
      tim_exit = {8'd4, 8'd5};
   endtask

   task automatic test_basic();
      set_std();
      run_burst(5, 0, 0, 0, 1);
      check_data("basic", 2, 6, 3, 5, 5);
      check_clock("basic", 3, 5, 2, 4);
   endtask

   task automatic test_zero_fields();
      tim_clk  = '0;
      tim_dat  = '0;
      tim_exit = '0;
      run_burst(3, 0, 0, 0, 1);
      check_data("R3 zeros", 1, 1, 1, 1, 3);
      check_clock("R3 zeros", 1, 1, 1, 1);
   endtask

   task automatic test_capture();
      set_std();
      run_burst(4, 0, 0, 1, 1);
      check_data("R9 capture", 2, 6, 3, 5, 4);
      check_clock("R9 capture", 3, 5, 2, 4);
      set_std();
   endtask

   task automatic test_eob_early();
      set_std();
      tim_dat = pack3(4, 3, 5);
      run_burst(6, 1, 1, 0, 1);
      check_data("R6 early eob R10 extra req", 4, 3, 5, 5, 6);
      check_clock("R6 early eob", 3, 5, 2, 4);
   endtask

   task automatic test_continuous();
      int guard;
      set_std();
      clk_cont = 1'b1;
      guard = 0;
      while (!(clk_hs_en && !clk_zero) && guard < 500) begin tick(); guard++; end
      check_eq("R8 clock starts alone", int'(clk_hs_en && !clk_zero), 1);
      check_eq("R8 data stays idle", int'(dat_busy), 0);
      run_burst(4, 0, 0, 0, 0);
      check_data("R8 cont", 2, 6, 3, 5, 4);
      check_eq("R8 no clock restart", c_lp01, 0);
      check_eq("R8 no clock trail", c_trail, 0);
      check_eq("R8 clock still running", int'(clk_hs_en && !clk_zero && clk_busy), 1);
      clear_mon();
      clk_cont = 1'b0;
      guard = 0;
      while (clk_busy && guard < 500) begin tick(); guard++; end
      tick();
      check_eq("R8 shutdown trail", c_trail, 2);
      check_eq("R8 shutdown exit", c_exit, 4);
      check_eq("R8 shutdown lp", int'(clk_lp), 3);
   endtask

   initial begin
      mon_clr = 1'b1;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      mon_clr = 1'b0;
      tick();
      test_reset();
      test_basic();
      test_zero_fields();
      test_capture();
      test_eob_early();
      test_continuous();
      summary();
      $finish;
   end

endmodule